// File: doc/BRIEF.md
# Fetch-Window Line-Pair Aligner

This block sits at the head of an instruction-fetch pipeline for a byte-aligned instruction set whose instructions vary in length. It chooses each fetch address from four candidates. A misprediction redirect ranks highest, then a trap or interrupt vector, then a predicted-taken branch target, and last the sequential address plus 16. For each fetch it reads the addressed 32-byte line and the line after it from a small built-in instruction memory. It rotates the 64 combined bytes so that the byte at the fetch address becomes byte 0, and it presents a 16-byte window over a valid/ready handshake. Every byte of the window carries an instruction-start flag and an instruction-end flag, computed with a fixed length rule.

Selection, the two-line read and the rotate-and-mark step each take one clock, so the block is a three-stage pipeline. A control state machine has two states. `ST_IDLE` is entered at reset, and in it no fetch is issued. `ST_STREAM` issues one fetch per advancing cycle. The transition `ST_IDLE -> ST_STREAM` fires on any misprediction or trap redirect. The transition `ST_STREAM -> ST_STREAM` on a redirect reloads the fetch address and flushes every window in flight. Without a redirect, `ST_IDLE` stays where it is, and `ST_STREAM` either advances or holds.

When the output is not accepted, all three stages stall together. When an instruction runs past the end of a window, the number of bytes it leaves over is carried into the next sequential window, which places that end mark first.

Top module: `fetch_window_aligner`

## Requirements
- R1: After reset `win_valid` is 0 and the state machine is idle. No window is produced and the predictor inputs have no effect until the first misprediction or trap redirect.
- R2: A redirect sampled at clock edge k gives `win_valid` = 0 after edges k and k+1. After edge k+2 the block shows a valid window with `win_addr` equal to the redirect address.
- R3: Selection priority is: misprediction (`mp_valid`/`mp_addr`) over trap (`trap_valid`/`trap_addr`) over predicted target (`bp_taken`/`bp_target`) over sequential.
- R4: Without a redirect or a predicted target, each window's address is the previous window's address plus 16, modulo 256.
- R5: For a window at address A, byte k (`win_bytes[8k+7:8k]`) equals M[(A+k) mod 256], where M[x] = ((29*x + 7) xor (x >> 2)) mod 256. The window is taken from line A/32 and line (A/32 + 1) mod 8, so it wraps at the top of memory.
- R6: Bit k of `win_start` and of `win_end` marks byte k. An instruction's length is (first byte AND 3) + 1. A window that follows a redirect or a predicted target starts marking at byte 0. An end that falls beyond byte 15 is not marked in that window.
- R7: If the previous window's last instruction ran c bytes (1 to 3) into a sequential window, that window marks `win_end` bit c-1 and its first start is byte c.
- R8: While `win_valid` is 1 and `win_ready` is 0, the window and its marks stay unchanged. Accepted windows follow the R4 sequence with none lost or repeated.
- R9: A redirect drops every window in flight, including one held at the output. `win_valid` is 0 after the edge that samples the redirect.
- R10: A predicted-taken target sampled while streaming is fetched next. The two windows already in flight are still delivered first, and marking in the target window restarts at byte 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mp_valid | input | 1 | Misprediction redirect request |
| mp_addr | input | 8 | Misprediction redirect address |
| trap_valid | input | 1 | Trap or interrupt redirect request |
| trap_addr | input | 8 | Trap or interrupt vector address |
| bp_taken | input | 1 | Predictor says the next fetch is a taken branch |
| bp_target | input | 8 | Predicted branch target address |
| win_ready | input | 1 | Downstream accepts the window |
| win_valid | output | 1 | Window is valid |
| win_addr | output | 8 | Fetch address of byte 0 of the window |
| win_bytes | output | 128 | Justified window, byte k at bits 8k+7:8k |
| win_start | output | 16 | Instruction-start flag per byte |
| win_end | output | 16 | Instruction-end flag per byte |

## Verification
The bench sweeps a redirect to every one of the 256 byte addresses and follows each with three sequential windows. This covers every in-line offset, the windows that span two lines, and the wrap from the top line back to line 0. A wrong line-pair index or a bad rotate shows up there as shifted or stale bytes. The carry of partial instructions across windows is checked by a model that recomputes the marks. A design that drops the carry, or that keeps it after a jump, marks a false start at byte 0 or misses the end mark. Targeted cases cover two redirects in the same cycle, a trap together with a prediction, and a prediction in mid-stream. A pseudo-random ready pattern and a redirect that arrives during a stall check that windows are never lost or repeated and that a held window is really discarded.

// File: rtl/fwa_pkg.sv
`timescale 1ns/1ps
package fwa_pkg;
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_STREAM = 1'b1
    } fetch_state_e;

    // Fixed length rule: low bits of the first byte give length minus one
    localparam int MAX_INSN_BYTES = 4;
    localparam int LEN_W          = $clog2(MAX_INSN_BYTES);
    localparam int CARRY_W        = $clog2(MAX_INSN_BYTES);
endpackage

// File: rtl/fwa_next_sel.sv
`timescale 1ns/1ps
// Stage 1: next-fetch-address selection and the fetch control state machine
module fwa_next_sel
    import fwa_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int WIN_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mp_valid,
    input  logic [ADDR_W-1:0] mp_addr,
    input  logic              trap_valid,
    input  logic [ADDR_W-1:0] trap_addr,
    input  logic              bp_taken,
    input  logic [ADDR_W-1:0] bp_target,
    input  logic              advance,
    output logic              flush,
    output logic              s1_valid,
    output logic [ADDR_W-1:0] s1_addr,
    output logic              s1_seq
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WIN_BYTES);

    fetch_state_e      state_q, state_d;
    logic [ADDR_W-1:0] pc_q, pc_d;
    logic [ADDR_W-1:0] addr_d;
    logic              valid_d, seq_d;
    logic              redirect;
    logic [ADDR_W-1:0] redirect_addr;
    logic [ADDR_W-1:0] stream_addr;

    assign redirect      = mp_valid | trap_valid;
    assign redirect_addr = mp_valid ? mp_addr : trap_addr;
    assign stream_addr   = bp_taken ? bp_target : pc_q;
    assign flush         = redirect;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Fetch registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q     <= '0;
            s1_valid <= 1'b0;
            s1_addr  <= '0;
            s1_seq   <= 1'b0;
        end else begin
            pc_q     <= pc_d;
            s1_valid <= valid_d;
            s1_addr  <= addr_d;
            s1_seq   <= seq_d;
        end
    end

    // Next state and stage-1 contents
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        valid_d = s1_valid;
        addr_d  = s1_addr;
        seq_d   = s1_seq;
        if (redirect) begin
            state_d = ST_STREAM;
            valid_d = 1'b1;
            addr_d  = redirect_addr;
            seq_d   = 1'b0;
            pc_d    = redirect_addr + STEP;
        end else if (advance) begin
            unique case (state_q)
                ST_IDLE: begin
                    valid_d = 1'b0;
                end
                ST_STREAM: begin
                    valid_d = 1'b1;
                    addr_d  = stream_addr;
                    seq_d   = !bp_taken;
                    pc_d    = stream_addr + STEP;
                end
            endcase
        end
    end
endmodule

// File: rtl/fwa_line_read.sv
`timescale 1ns/1ps
// Stage 2: read the addressed line and its successor from the built-in memory
module fwa_line_read #(
    parameter int  LINE_BYTES = 32,
    parameter int  MEM_LINES  = 8,
    parameter int  BYTE_MUL   = 29,
    parameter int  BYTE_ADD   = 7,
    parameter int  ADDR_W     = 8,
    localparam int OFF_W      = $clog2(LINE_BYTES),
    localparam int PAIR_W     = 2 * LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              flush,
    input  logic              s1_valid,
    input  logic [ADDR_W-1:0] s1_addr,
    input  logic              s1_seq,
    output logic              s2_valid,
    output logic [PAIR_W-1:0] s2_pair,
    output logic [OFF_W-1:0]  s2_off,
    output logic [ADDR_W-1:0] s2_addr,
    output logic              s2_seq
);
    localparam int MEM_BYTES = LINE_BYTES * MEM_LINES;
    localparam int IDX_W     = ADDR_W - OFF_W;

    logic [7:0]        rom [MEM_BYTES];
    logic [IDX_W-1:0]  idx_lo, idx_hi;
    logic [PAIR_W-1:0] pair_d;

    for (genvar g = 0; g < MEM_BYTES; g++) begin : g_rom
        assign rom[g] = 8'(((g * BYTE_MUL) + BYTE_ADD) ^ (g >> 2));
    end

    assign idx_lo = s1_addr[ADDR_W-1:OFF_W];
    assign idx_hi = idx_lo + IDX_W'(1);

    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_pair
        assign pair_d[b*8 +: 8]                = rom[{idx_lo, OFF_W'(b)}];
        assign pair_d[(LINE_BYTES+b)*8 +: 8]   = rom[{idx_hi, OFF_W'(b)}];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_pair  <= '0;
            s2_off   <= '0;
            s2_addr  <= '0;
            s2_seq   <= 1'b0;
        end else if (flush) begin
            s2_valid <= 1'b0;
        end else if (advance) begin
            s2_valid <= s1_valid;
            s2_pair  <= pair_d;
            s2_off   <= s1_addr[OFF_W-1:0];
            s2_addr  <= s1_addr;
            s2_seq   <= s1_seq;
        end
    end
endmodule

// File: rtl/fwa_rotate_mark.sv
`timescale 1ns/1ps
// Stage 3 logic: justify the window and mark instruction boundaries
module fwa_rotate_mark
    import fwa_pkg::*;
#(
    parameter int  LINE_BYTES = 32,
    parameter int  WIN_BYTES  = 16,
    localparam int OFF_W      = $clog2(LINE_BYTES),
    localparam int PAIR_W     = 2 * LINE_BYTES * 8,
    localparam int WIN_W      = WIN_BYTES * 8
) (
    input  logic [PAIR_W-1:0]    pair,
    input  logic [OFF_W-1:0]     off,
    input  logic                 seq,
    input  logic [CARRY_W-1:0]   carry_in,
    output logic [WIN_W-1:0]     win,
    output logic [WIN_BYTES-1:0] starts,
    output logic [WIN_BYTES-1:0] ends,
    output logic [CARRY_W-1:0]   carry_out
);
    always_comb begin : rotate
        for (int k = 0; k < WIN_BYTES; k++) begin
            win[k*8 +: 8] = pair[(int'(off) + k)*8 +: 8];
        end
    end

    always_comb begin : mark
        int nxt;
        int last;
        starts = '0;
        ends   = '0;
        last   = 0;
        nxt    = seq ? int'(carry_in) : 0;
        if (nxt != 0) begin
            ends[nxt-1] = 1'b1;
        end
        for (int i = 0; i < WIN_BYTES; i++) begin
            if (i == nxt) begin
                starts[i] = 1'b1;
                last      = i + int'(win[i*8 +: LEN_W]);
                if (last < WIN_BYTES) begin
                    ends[last] = 1'b1;
                end
                nxt = last + 1;
            end
        end
        carry_out = (nxt > WIN_BYTES) ? CARRY_W'(nxt - WIN_BYTES) : '0;
    end
endmodule

// File: rtl/fetch_window_aligner.sv
`timescale 1ns/1ps
module fetch_window_aligner #(
    parameter int  LINE_BYTES = 32,
    parameter int  MEM_LINES  = 8,
    parameter int  WIN_BYTES  = 16,
    parameter int  BYTE_MUL   = 29,
    parameter int  BYTE_ADD   = 7,
    localparam int ADDR_W     = $clog2(LINE_BYTES * MEM_LINES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mp_valid,
    input  logic [ADDR_W-1:0]      mp_addr,
    input  logic                   trap_valid,
    input  logic [ADDR_W-1:0]      trap_addr,
    input  logic                   bp_taken,
    input  logic [ADDR_W-1:0]      bp_target,
    input  logic                   win_ready,
    output logic                   win_valid,
    output logic [ADDR_W-1:0]      win_addr,
    output logic [WIN_BYTES*8-1:0] win_bytes,
    output logic [WIN_BYTES-1:0]   win_start,
    output logic [WIN_BYTES-1:0]   win_end
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int PAIR_W = 2 * LINE_BYTES * 8;
    localparam int WIN_W  = WIN_BYTES * 8;

    logic                        advance, flush;
    logic                        s1_valid, s1_seq;
    logic [ADDR_W-1:0]           s1_addr;
    logic                        s2_valid, s2_seq;
    logic [PAIR_W-1:0]           s2_pair;
    logic [OFF_W-1:0]            s2_off;
    logic [ADDR_W-1:0]           s2_addr;
    logic [WIN_W-1:0]            rot_win;
    logic [WIN_BYTES-1:0]        rot_start, rot_end;
    logic [fwa_pkg::CARRY_W-1:0] carry_q, carry_d;

    // Whole pipeline moves only when the output slot is free or taken
    assign advance = !win_valid || win_ready;

    fwa_next_sel #(
        .ADDR_W   (ADDR_W),
        .WIN_BYTES(WIN_BYTES)
    ) u_next_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .mp_valid  (mp_valid),
        .mp_addr   (mp_addr),
        .trap_valid(trap_valid),
        .trap_addr (trap_addr),
        .bp_taken  (bp_taken),
        .bp_target (bp_target),
        .advance   (advance),
        .flush     (flush),
        .s1_valid  (s1_valid),
        .s1_addr   (s1_addr),
        .s1_seq    (s1_seq)
    );

    fwa_line_read #(
        .LINE_BYTES(LINE_BYTES),
        .MEM_LINES (MEM_LINES),
        .BYTE_MUL  (BYTE_MUL),
        .BYTE_ADD  (BYTE_ADD),
        .ADDR_W    (ADDR_W)
    ) u_line_read (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .flush   (flush),
        .s1_valid(s1_valid),
        .s1_addr (s1_addr),
        .s1_seq  (s1_seq),
        .s2_valid(s2_valid),
        .s2_pair (s2_pair),
        .s2_off  (s2_off),
        .s2_addr (s2_addr),
        .s2_seq  (s2_seq)
    );

    fwa_rotate_mark #(
        .LINE_BYTES(LINE_BYTES),
        .WIN_BYTES (WIN_BYTES)
    ) u_rotate_mark (
        .pair     (s2_pair),
        .off      (s2_off),
        .seq      (s2_seq),
        .carry_in (carry_q),
        .win      (rot_win),
        .starts   (rot_start),
        .ends     (rot_end),
        .carry_out(carry_d)
    );

    // Stage 3: output window register and cross-window carry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_valid <= 1'b0;
            win_addr  <= '0;
            win_bytes <= '0;
            win_start <= '0;
            win_end   <= '0;
            carry_q   <= '0;
        end else if (flush) begin
            win_valid <= 1'b0;
        end else if (advance) begin
            win_valid <= s2_valid;
            if (s2_valid) begin
                win_addr  <= s2_addr;
                win_bytes <= rot_win;
                win_start <= rot_start;
                win_end   <= rot_end;
                carry_q   <= carry_d;
            end
        end
    end
endmodule

// File: rtl/fwa_checker.sv
`timescale 1ns/1ps
module fwa_checker #(
    parameter int ADDR_W    = 8,
    parameter int WIN_BYTES = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   mp_valid,
    input logic [ADDR_W-1:0]      mp_addr,
    input logic                   trap_valid,
    input logic [ADDR_W-1:0]      trap_addr,
    input logic                   win_valid,
    input logic                   win_ready,
    input logic [ADDR_W-1:0]      win_addr,
    input logic [WIN_BYTES*8-1:0] win_bytes,
    input logic [WIN_BYTES-1:0]   win_start,
    input logic [WIN_BYTES-1:0]   win_end
);
    logic redir;
    logic seen_q;

    assign redir = mp_valid | trap_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else if (redir) begin
            seen_q <= 1'b1;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !win_valid);

    assert_trap_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(trap_valid && !mp_valid, 3) && !$past(redir, 2) && !$past(redir, 1))
        |-> (win_valid && win_addr == $past(trap_addr, 3)));

    assert_mp_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mp_valid, 3) && !$past(redir, 2) && !$past(redir, 1))
        |-> (win_valid && win_addr == $past(mp_addr, 3)));

    assert_first_start_near_R6: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (win_start[3:0] != 4'b0000));

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !win_ready && !redir)
        |=> (win_valid && $stable(win_addr) && $stable(win_bytes)
             && $stable(win_start) && $stable(win_end)));

    assert_flush_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        redir |=> !win_valid);
endmodule

bind fetch_window_aligner fwa_checker #(
    .ADDR_W   (ADDR_W),
    .WIN_BYTES(WIN_BYTES)
) u_fwa_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .mp_valid  (mp_valid),
    .mp_addr   (mp_addr),
    .trap_valid(trap_valid),
    .trap_addr (trap_addr),
    .win_valid (win_valid),
    .win_ready (win_ready),
    .win_addr  (win_addr),
    .win_bytes (win_bytes),
    .win_start (win_start),
    .win_end   (win_end)
);

// File: tb/test_fetch_window_aligner.sv
`timescale 1ns/1ps
module test_fetch_window_aligner;
    localparam int LINE_BYTES = 32;
    localparam int MEM_LINES  = 8;
    localparam int WIN_BYTES  = 16;
    localparam int BYTE_MUL   = 29;
    localparam int BYTE_ADD   = 7;
    localparam int MEM_BYTES  = LINE_BYTES * MEM_LINES;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mp_valid = 1'b0;
    logic [7:0]   mp_addr = '0;
    logic         trap_valid = 1'b0;
    logic [7:0]   trap_addr = '0;
    logic         bp_taken = 1'b0;
    logic [7:0]   bp_target = '0;
    logic         win_ready = 1'b1;
    logic         win_valid;
    logic [7:0]   win_addr;
    logic [127:0] win_bytes;
    logic [15:0]  win_start, win_end;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fetch_window_aligner #(
        .LINE_BYTES(LINE_BYTES), .MEM_LINES(MEM_LINES), .WIN_BYTES(WIN_BYTES),
        .BYTE_MUL(BYTE_MUL), .BYTE_ADD(BYTE_ADD)
    ) i_fetch_window_aligner (
        .clk(clk), .rst_n(rst_n),
        .mp_valid(mp_valid), .mp_addr(mp_addr),
        .trap_valid(trap_valid), .trap_addr(trap_addr),
        .bp_taken(bp_taken), .bp_target(bp_target),
        .win_ready(win_ready), .win_valid(win_valid), .win_addr(win_addr),
        .win_bytes(win_bytes), .win_start(win_start), .win_end(win_end)
    );

    function automatic logic [7:0] mem_at(input int a);
        int m;
        m = a % MEM_BYTES;
        return 8'(((m * BYTE_MUL) + BYTE_ADD) ^ (m >> 2));
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Boundary marks from the length rule, walking instruction by instruction
    task automatic model_marks(input logic [7:0] base, input int cin,
                               output logic [15:0] st, output logic [15:0] en,
                               output int cout);
        int p;
        int len;
        st = '0;
        en = '0;
        p  = cin;
        if (cin > 0) en[cin-1] = 1'b1;
        while (p < WIN_BYTES) begin
            len   = int'(mem_at(int'(base) + p) & 8'h03) + 1;
            st[p] = 1'b1;
            if (p + len - 1 < WIN_BYTES) en[p+len-1] = 1'b1;
            p = p + len;
        end
        cout = p - WIN_BYTES;
    endtask

    task automatic expect_window(input logic [7:0] a, input int cin,
                                 output int cout, input string req);
        logic [127:0] eb;
        logic [15:0]  es, ee;
        for (int k = 0; k < WIN_BYTES; k++) eb[k*8 +: 8] = mem_at(int'(a) + k);
        model_marks(a, cin, es, ee, cout);
        check(win_valid === 1'b1, req, "window valid", 128'(win_valid), 128'(1));
        check(win_addr === a, req, "window address", 128'(win_addr), 128'(a));
        check(win_bytes === eb, "R5", "window bytes", win_bytes, eb);
        check(win_start === es, (cin > 0) ? "R7" : "R6", "start marks",
              128'(win_start), 128'(es));
        check(win_end === ee, (cin > 0) ? "R7" : "R6", "end marks",
              128'(win_end), 128'(ee));
    endtask

    // Called at the negedge where the redirect inputs are already set
    task automatic settle_redirect();
        @(negedge clk);
        mp_valid   = 1'b0;
        trap_valid = 1'b0;
        bp_taken   = 1'b0;
        check(win_valid === 1'b0, "R9", "valid after redirect edge", 128'(win_valid), 128'(0));
        @(negedge clk);
        check(win_valid === 1'b0, "R2", "valid one edge later", 128'(win_valid), 128'(0));
        @(negedge clk);
    endtask

    task automatic do_redirect(input bit use_mp, input logic [7:0] a);
        if (use_mp) begin
            mp_valid = 1'b1;
            mp_addr  = a;
        end else begin
            trap_valid = 1'b1;
            trap_addr  = a;
        end
        settle_redirect();
    endtask

    initial begin
        int cin;
        int cout;
        logic [7:0]  exp_a;
        logic [15:0] lfsr;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(win_valid === 1'b0, "R1", "valid after reset", 128'(win_valid), 128'(0));
        bp_taken  = 1'b1;
        bp_target = 8'h33;
        repeat (5) begin
            @(negedge clk);
            check(win_valid === 1'b0, "R1", "valid while idle with prediction",
                  128'(win_valid), 128'(0));
        end
        bp_taken = 1'b0;

        // Every start address, both redirect sources, three sequential follow-ons
        for (int a = 0; a < MEM_BYTES; a++) begin
            do_redirect(a[0], 8'(a));
            cin = 0;
            for (int j = 0; j < 4; j++) begin
                expect_window(8'(a + 16 * j), cin, cout, (j == 0) ? "R2" : "R4");
                cin = cout;
                if (j < 3) @(negedge clk);
            end
        end

        // R3: misprediction beats trap in the same cycle
        mp_valid = 1'b1; mp_addr = 8'h45;
        trap_valid = 1'b1; trap_addr = 8'h90;
        settle_redirect();
        expect_window(8'h45, 0, cout, "R3");

        // R3: trap beats a simultaneous prediction
        trap_valid = 1'b1; trap_addr = 8'h90;
        bp_taken = 1'b1; bp_target = 8'h20;
        settle_redirect();
        expect_window(8'h90, 0, cout, "R3");

        // R10: prediction mid-stream, two in-flight windows still delivered
        cin = cout;
        bp_taken = 1'b1; bp_target = 8'hA7;
        @(negedge clk);
        bp_taken = 1'b0;
        expect_window(8'hA0, cin, cout, "R10");
        cin = cout;
        @(negedge clk);
        expect_window(8'hB0, cin, cout, "R10");
        @(negedge clk);
        expect_window(8'hA7, 0, cout, "R10");
        cin = cout;
        @(negedge clk);
        expect_window(8'hB7, cin, cout, "R10");

        // R8: pseudo-random backpressure over a stream
        do_redirect(1'b1, 8'h5B);
        exp_a = 8'h5B;
        cin   = 0;
        lfsr  = 16'hACE1;
        for (int it = 0; it < 80; it++) begin
            expect_window(exp_a, cin, cout, "R8");
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            win_ready = lfsr[0];
            if (win_ready) begin
                exp_a = exp_a + 8'd16;
                cin   = cout;
            end
            @(negedge clk);
        end

        // R9: redirect while a window is held
        win_ready = 1'b0;
        @(negedge clk);
        trap_valid = 1'b1; trap_addr = 8'hC3;
        settle_redirect();
        expect_window(8'hC3, 0, cout, "R9");
        cin = cout;
        @(negedge clk);
        expect_window(8'hC3, 0, cout, "R8");
        win_ready = 1'b1;
        @(negedge clk);
        expect_window(8'hD3, cin, cout, "R4");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule